// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block serves the configuration step of a vector engine. A request carries an application vector length (the number of elements software still wants processed) together with a requested type: element width, register group multiplier, and two policy bits for tail and masked-off elements. One clock later the unit presents the granted vector length and holds the accepted type as architectural state. Configurations that this implementation cannot run are flagged by an illegal-type bit in that state.

Between configuration requests the unit screens each vector operation that issues. It checks the destination and both source register indices against the current group size. An operation traps when an index is misaligned or when the held type is illegal. The register width and the widest supported element are elaboration parameters.

Top module: `vcfg_unit`

## Requirements
- R1: After reset the granted length is 0, the illegal-type bit is 1, the width, multiplier and policy fields are 0, and no trap is raised.
- R2: Element width code 0,1,2,3 selects 8,16,32,64 bits. Multiplier code 0,1,2,3 selects 1,2,4,8, and code 5,6,7 selects 1/8,1/4,1/2. The maximum count is the register width times the multiplier divided by the element width. One cycle after a request is accepted, the granted length is the request when it does not exceed that maximum, and the maximum otherwise.
- R3: A fractional multiplier whose maximum count comes out below one element is illegal.
- R4: Element width codes 4 to 7, multiplier code 4, and any element width above the widest supported element are illegal.
- R5: An accepted illegal request sets the illegal-type bit and grants length 0. An accepted legal request clears the bit and latches the width, multiplier and both policy bits as requested.
- R6: While no request is presented, the granted length and the whole type state keep their values.
- R7: While the illegal-type bit is set, every issued operation traps, whatever its register indices.
- R8: With an integer multiplier of 2, 4 or 8, an operation traps if its destination or either source index is not a multiple of the multiplier. A multiplier of 1 or a fractional multiplier places no restriction on indices.
- R9: The trap is a one-cycle pulse, raised in the cycle after an issued operation and never without one. It is judged against the type state held before any request accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration request strobe |
| cfg_avl | input | AVL_W | Requested application vector length |
| cfg_sew | input | 3 | Element width code |
| cfg_lmul | input | 3 | Register group multiplier code |
| cfg_tail_agn | input | 1 | Requested tail policy (1 = agnostic) |
| cfg_mask_agn | input | 1 | Requested masked-element policy (1 = agnostic) |
| vl | output | clog2(VLEN)+1 | Granted vector length |
| vt_sew | output | 3 | Held element width code |
| vt_lmul | output | 3 | Held multiplier code |
| vt_tail_agn | output | 1 | Held tail policy |
| vt_mask_agn | output | 1 | Held masked-element policy |
| vt_ill | output | 1 | Illegal-type bit |
| op_valid | input | 1 | Vector operation issues this cycle |
| op_vd | input | 5 | Destination register index |
| op_vs1 | input | 5 | First source register index |
| op_vs2 | input | 5 | Second source register index |
| op_trap | output | 1 | Trap pulse for the issued operation |

## Verification
The properties assume that the request and operation strobes are clean single-bit levels. They also assume the index and code inputs are stable around the sampling edge. They assume nothing about how often a request comes or what it contains, since reserved codes are part of the legality rule. The stimulus drives every input on the falling edge and holds it for a full cycle. It walks every width and multiplier code, including the reserved ones, with lengths just below, at and above each maximum. Every register index is issued under each held type, so each property is reached through legal inputs only.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

   localparam int unsigned CODE_W   = 3;
   localparam int unsigned REG_W    = 5;
   localparam int unsigned N_OPERND = 3;

   // multiplier code 4 is reserved, 5..7 are fractional
   localparam logic [CODE_W-1:0] LMUL_RSV = 3'd4;

   typedef struct packed {
      logic [CODE_W-1:0] sew;
      logic [CODE_W-1:0] lmul;
      logic              tail_agn;
      logic              mask_agn;
      logic              ill;
   } vtype_t;

   function automatic logic lmul_is_int(input logic [CODE_W-1:0] code);
      return (code[2] == 1'b0);
   endfunction

   // log2 of the multiplier, two's complement in 8 bits
   function automatic logic signed [7:0] lmul_log2(input logic [CODE_W-1:0] code);
      logic signed [7:0] r;
      case (code)
         3'd0:    r = 8'sd0;
         3'd1:    r = 8'sd1;
         3'd2:    r = 8'sd2;
         3'd3:    r = 8'sd3;
         3'd5:    r = -8'sd3;
         3'd6:    r = -8'sd2;
         3'd7:    r = -8'sd1;
         default: r = 8'sd0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/vcfg_limit.sv
module vcfg_limit
   import vcfg_pkg::*;
#(
   parameter int unsigned VLEN  = 128,
   parameter int unsigned ELEN  = 64,
   parameter int unsigned AVL_W = 16,
   localparam int unsigned LOG_VLEN = $clog2(VLEN),
   localparam int unsigned VL_W     = LOG_VLEN + 1
) (
   input  logic [AVL_W-1:0]  avl,
   input  logic [CODE_W-1:0] sew,
   input  logic [CODE_W-1:0] lmul,
   output logic              legal,
   output logic [VL_W-1:0]   grant
);

   logic signed [7:0] exp_s;
   logic [VL_W-1:0]   vlmax;
   logic              width_ok;
   logic [AVL_W-1:0]  vlmax_ext;

   // element widths above ELEN are only possible when ELEN < 64
   if (ELEN >= 64) begin : g_full_width
      assign width_ok = (sew[2] == 1'b0);
   end else begin : g_narrow_width
      assign width_ok = (sew[2] == 1'b0) && ((32'd8 << sew[1:0]) <= ELEN);
   end

   // log2(maximum) = log2(VLEN) + log2(multiplier) - log2(element width)
   always_comb begin
      exp_s = 8'(LOG_VLEN) + lmul_log2(lmul) - 8'sd3 - {6'd0, sew[1:0]};
      legal = width_ok && (lmul != LMUL_RSV) && !exp_s[7];
      vlmax = exp_s[7] ? '0 : (VL_W'(1) << exp_s[3:0]);
   end

   assign vlmax_ext = AVL_W'(vlmax);

   always_comb begin
      if (!legal)
         grant = '0;
      else if (avl <= vlmax_ext)
         grant = VL_W'(avl);
      else
         grant = vlmax;
   end

endmodule

// File: rtl/vcfg_state.sv
module vcfg_state
   import vcfg_pkg::*;
#(
   parameter int unsigned VL_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  vtype_t          nxt_type,
   input  logic [VL_W-1:0] nxt_vl,
   output vtype_t          cur_type,
   output logic [VL_W-1:0] cur_vl
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_type     <= '0;
         cur_type.ill <= 1'b1;
         cur_vl       <= '0;
      end else if (load) begin
         cur_type <= nxt_type;
         cur_vl   <= nxt_vl;
      end
   end

endmodule

// File: rtl/vcfg_align.sv
module vcfg_align
   import vcfg_pkg::*;
(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         op_valid,
   input  logic [N_OPERND-1:0][REG_W-1:0] idx,
   input  logic [CODE_W-1:0]            lmul,
   input  logic                         ill,
   output logic                         trap
);

   logic [N_OPERND-1:0] mis;
   logic [REG_W-1:0]    low_mask;

   assign low_mask = lmul_is_int(lmul) ? REG_W'((5'd1 << lmul[1:0]) - 5'd1) : '0;

   for (genvar g = 0; g < N_OPERND; g++) begin : g_operand
      assign mis[g] = |(idx[g] & low_mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         trap <= 1'b0;
      else
         trap <= op_valid && (ill || (|mis));
   end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
   import vcfg_pkg::*;
#(
   parameter int unsigned VLEN  = 128,
   parameter int unsigned ELEN  = 64,
   parameter int unsigned AVL_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_valid,
   input  logic [AVL_W-1:0]         cfg_avl,
   input  logic [2:0]               cfg_sew,
   input  logic [2:0]               cfg_lmul,
   input  logic                     cfg_tail_agn,
   input  logic                     cfg_mask_agn,
   output logic [$clog2(VLEN):0]    vl,
   output logic [2:0]               vt_sew,
   output logic [2:0]               vt_lmul,
   output logic                     vt_tail_agn,
   output logic                     vt_mask_agn,
   output logic                     vt_ill,
   input  logic                     op_valid,
   input  logic [4:0]               op_vd,
   input  logic [4:0]               op_vs1,
   input  logic [4:0]               op_vs2,
   output logic                     op_trap
);

   localparam int unsigned VL_W = $clog2(VLEN) + 1;

   if ((VLEN & (VLEN - 1)) != 0 || VLEN < 8) begin : g_bad_vlen
      $error("vcfg_unit: VLEN must be a power of two of at least 8");
   end
   if ((ELEN & (ELEN - 1)) != 0 || ELEN < 8 || ELEN > VLEN) begin : g_bad_elen
      $error("vcfg_unit: ELEN must be a power of two between 8 and VLEN");
   end
   if (AVL_W < VL_W) begin : g_bad_avl
      $error("vcfg_unit: AVL_W too narrow for the largest grant");
   end

   logic            legal;
   logic [VL_W-1:0] grant;
   vtype_t          nxt_type;
   vtype_t          cur_type;

   vcfg_limit #(.VLEN(VLEN), .ELEN(ELEN), .AVL_W(AVL_W)) i_limit (
      .avl   (cfg_avl),
      .sew   (cfg_sew),
      .lmul  (cfg_lmul),
      .legal (legal),
      .grant (grant)
   );

   always_comb begin
      nxt_type.sew      = legal ? cfg_sew      : '0;
      nxt_type.lmul     = legal ? cfg_lmul     : '0;
      nxt_type.tail_agn = legal ? cfg_tail_agn : 1'b0;
      nxt_type.mask_agn = legal ? cfg_mask_agn : 1'b0;
      nxt_type.ill      = !legal;
   end

   vcfg_state #(.VL_W(VL_W)) i_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_valid),
      .nxt_type (nxt_type),
      .nxt_vl   (grant),
      .cur_type (cur_type),
      .cur_vl   (vl)
   );

   assign vt_sew      = cur_type.sew;
   assign vt_lmul     = cur_type.lmul;
   assign vt_tail_agn = cur_type.tail_agn;
   assign vt_mask_agn = cur_type.mask_agn;
   assign vt_ill      = cur_type.ill;

   vcfg_align i_align (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .idx      ({op_vs2, op_vs1, op_vd}),
      .lmul     (cur_type.lmul),
      .ill      (cur_type.ill),
      .trap     (op_trap)
   );

endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
   parameter int unsigned VLEN  = 128,
   parameter int unsigned AVL_W = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_valid,
   input logic [AVL_W-1:0]      cfg_avl,
   input logic [2:0]            cfg_sew,
   input logic [2:0]            cfg_lmul,
   input logic [$clog2(VLEN):0] vl,
   input logic [2:0]            vt_sew,
   input logic [2:0]            vt_lmul,
   input logic                  vt_tail_agn,
   input logic                  vt_mask_agn,
   input logic                  vt_ill,
   input logic                  op_valid,
   input logic [4:0]            op_vd,
   input logic                  op_trap
);

   AST_GRANT_NOT_ABOVE_AVL: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |=> (AVL_W'(vl) <= $past(cfg_avl))); // R2

   AST_RSV_WIDTH_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_sew[2]) |=> vt_ill); // R4

   AST_RSV_MULT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_lmul == 3'd4) |=> vt_ill); // R4

   AST_ILLEGAL_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      vt_ill |-> (vl == '0)); // R5

   AST_STATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_valid |=> ($stable(vl) && $stable(vt_ill) && $stable(vt_sew) && $stable(vt_lmul)
                      && $stable(vt_tail_agn) && $stable(vt_mask_agn))); // R6

   AST_ILLEGAL_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && vt_ill) |=> op_trap); // R7

   AST_MISALIGNED_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && vt_lmul == 3'd3 && op_vd[2:0] != 3'd0) |=> op_trap); // R8

   AST_TRAP_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
      op_trap |-> $past(op_valid)); // R9

endmodule

bind vcfg_unit vcfg_unit_chk #(.VLEN(VLEN), .AVL_W(AVL_W)) i_vcfg_unit_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_valid   (cfg_valid),
   .cfg_avl     (cfg_avl),
   .cfg_sew     (cfg_sew),
   .cfg_lmul    (cfg_lmul),
   .vl          (vl),
   .vt_sew      (vt_sew),
   .vt_lmul     (vt_lmul),
   .vt_tail_agn (vt_tail_agn),
   .vt_mask_agn (vt_mask_agn),
   .vt_ill      (vt_ill),
   .op_valid    (op_valid),
   .op_vd       (op_vd),
   .op_trap     (op_trap)
);

// File: tb/test_vcfg_unit.sv
module test_vcfg_unit;

   localparam int unsigned VLEN  = 64;
   localparam int unsigned ELEN  = 32;
   localparam int unsigned AVL_W = 16;
   localparam int unsigned VL_W  = $clog2(VLEN) + 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_valid = 1'b0;
   logic [AVL_W-1:0] cfg_avl = '0;
   logic [2:0]       cfg_sew = '0;
   logic [2:0]       cfg_lmul = '0;
   logic             cfg_tail_agn = 1'b0;
   logic             cfg_mask_agn = 1'b0;
   logic [VL_W-1:0]  vl;
   logic [2:0]       vt_sew;
   logic [2:0]       vt_lmul;
   logic             vt_tail_agn;
   logic             vt_mask_agn;
   logic             vt_ill;
   logic             op_valid = 1'b0;
   logic [4:0]       op_vd = '0;
   logic [4:0]       op_vs1 = '0;
   logic [4:0]       op_vs2 = '0;
   logic             op_trap;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // model of the held state
   bit m_ill  = 1;
   int m_lmul = 0;

   always #5 clk = ~clk;

   vcfg_unit #(.VLEN(VLEN), .ELEN(ELEN), .AVL_W(AVL_W)) i_vcfg_unit (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_avl(cfg_avl),
      .cfg_sew(cfg_sew), .cfg_lmul(cfg_lmul), .cfg_tail_agn(cfg_tail_agn),
      .cfg_mask_agn(cfg_mask_agn), .vl(vl), .vt_sew(vt_sew), .vt_lmul(vt_lmul),
      .vt_tail_agn(vt_tail_agn), .vt_mask_agn(vt_mask_agn), .vt_ill(vt_ill),
      .op_valid(op_valid), .op_vd(op_vd), .op_vs1(op_vs1), .op_vs2(op_vs2),
      .op_trap(op_trap)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // returns maximum count, or -1 when the configuration is illegal
   function automatic int ref_max(input int s, input int l);
      int bits;
      if (s > 3 || l == 4) return -1;
      bits = 8 << s;
      if (bits > ELEN) return -1;
      if (l < 4) return (VLEN << l) / bits;
      if ((VLEN >> (8 - l)) < bits) return -1;
      return (VLEN >> (8 - l)) / bits;
   endfunction

   task automatic do_cfg(input int avl, input int s, input int l, input bit ta, input bit ma);
      int mx;
      int ev;
      string req;
      mx = ref_max(s, l);
      @(negedge clk);
      cfg_avl = AVL_W'(avl); cfg_sew = 3'(s); cfg_lmul = 3'(l);
      cfg_tail_agn = ta; cfg_mask_agn = ma; cfg_valid = 1'b1;
      @(negedge clk);
      cfg_valid = 1'b0;
      if (mx < 0) begin
         req = (s > 3 || l == 4 || (8 << s) > ELEN) ? "R4" : "R3";
         check(vt_ill == 1'b1, req, int'(vt_ill), 1);
         check(vl == '0, "R5", int'(vl), 0);
         m_ill = 1; m_lmul = 0;
      end else begin
         ev = (avl <= mx) ? avl : mx;
         check(vl == VL_W'(ev), "R2", int'(vl), ev);
         check(vt_ill == 1'b0 && vt_sew == 3'(s) && vt_lmul == 3'(l)
               && vt_tail_agn == ta && vt_mask_agn == ma, "R5",
               int'({vt_ill, vt_sew, vt_lmul, vt_tail_agn, vt_mask_agn}),
               int'({1'b0, 3'(s), 3'(l), ta, ma}));
         m_ill = 0; m_lmul = l;
      end
   endtask

   function automatic bit ref_mis(input int idx);
      if (m_lmul >= 4) return 0;
      return (idx % (1 << m_lmul)) != 0;
   endfunction

   task automatic do_op(input int d, input int a, input int b);
      bit et;
      et = m_ill || ref_mis(d) || ref_mis(a) || ref_mis(b);
      @(negedge clk);
      op_vd = 5'(d); op_vs1 = 5'(a); op_vs2 = 5'(b); op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      check(op_trap == et, m_ill ? "R7" : "R8", int'(op_trap), int'(et));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int mx;
      int held;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(vl == '0 && vt_sew == '0 && vt_lmul == '0 && !vt_tail_agn && !vt_mask_agn,
            "R1", int'(vl), 0);
      check(vt_ill == 1'b1, "R1", int'(vt_ill), 1);
      check(op_trap == 1'b0, "R1", int'(op_trap), 0);
      rst_n = 1'b1;
      @(negedge clk);
      do_op(0, 0, 0); // R7 right after reset

      // R2 R3 R4 R5: every code pair with lengths around each maximum
      for (int s = 0; s < 8; s++) begin
         for (int l = 0; l < 8; l++) begin
            mx = ref_max(s, l);
            do_cfg(0, s, l, 1'b0, 1'b0);
            do_cfg(1, s, l, 1'b1, 1'b0);
            if (mx > 0) begin
               do_cfg(mx - 1, s, l, 1'b0, 1'b1);
               do_cfg(mx, s, l, 1'b1, 1'b1);
               do_cfg(mx + 1, s, l, 1'b0, 1'b0);
            end
            do_cfg(65535, s, l, 1'b1, 1'b0);
            // R7 R8: every destination index under this state
            for (int r = 0; r < 32; r++) do_op(r, 0, 0);
         end
      end

      // R8: source indices under a multiplier of 8 and of 4
      do_cfg(5, 0, 3, 1'b0, 0'b0);
      for (int r = 0; r < 32; r++) do_op(0, r, 0);
      for (int r = 0; r < 32; r++) do_op(0, 0, r);
      do_cfg(5, 0, 2, 1'b0, 1'b0);
      for (int r = 0; r < 32; r++) do_op(8, r, 16);

      // R9: pulse lasts one cycle
      do_op(1, 0, 0);
      @(negedge clk);
      check(op_trap == 1'b0, "R9", int'(op_trap), 0);

      // R6: request inputs change but no strobe
      do_cfg(9, 1, 1, 1'b1, 1'b0);
      held = int'(vl);
      @(negedge clk);
      cfg_avl = 16'd3; cfg_sew = 3'd7; cfg_lmul = 3'd4;
      repeat (4) @(negedge clk);
      check(vl == VL_W'(held) && !vt_ill && vt_sew == 3'd1 && vt_lmul == 3'd1
            && vt_tail_agn && !vt_mask_agn, "R6", int'(vl), held);

      // R9: operation judged against state before a same-cycle request
      @(negedge clk);
      cfg_avl = 16'd4; cfg_sew = 3'd5; cfg_lmul = 3'd0; cfg_valid = 1'b1;
      op_vd = 5'd2; op_vs1 = 5'd0; op_vs2 = 5'd4; op_valid = 1'b1;
      @(negedge clk);
      cfg_valid = 1'b0; op_valid = 1'b0;
      check(op_trap == 1'b0, "R9", int'(op_trap), 0);
      check(vt_ill == 1'b1, "R4", int'(vt_ill), 1);
      m_ill = 1; m_lmul = 0;
      do_op(2, 0, 4); // R7 now traps
      do_cfg(4, 0, 0, 1'b0, 1'b0);
      do_op(3, 5, 7); // cleared state, multiplier 1

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule